// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block runs single read and write accesses on one chip-select of an external asynchronous parallel memory. A host offers a request (direction, address, write data). When the sequencer is free it takes the request and starts an access cycle. Every strobe edge, the read sampling point and the cycle length are static configuration inputs given in ticks. Tick 0 is the first tick of the access. A tick lasts one, two, three or four clock cycles, set by a divider field.

The block drives active-low chip-select, address-valid, output-enable and write-enable. It also drives a separate address port and a shared data bus, given as output value, output enable and input value. The shared bus carries address in two multiplexed modes. A wait input can freeze the access at its sampling tick, and this can be enabled separately for reads and for writes. At the end of every access the block raises a done pulse for one clock. During that pulse the read result is valid.

Top module: `amem_strobe_seq`

## Requirements
- R1: In reset and while idle, all four strobes are high, the shared bus output enable is low, `req_ready` is high and `done` is low.
- R2: With divider value d, one tick lasts d+1 clock cycles. Clock cycle c after acceptance (c=0 is the cycle right after the accepting edge) belongs to tick floor(c/(d+1)).
- R3: Chip-select is low in ticks t where on <= t < off. For reads, off is `cfg_cs_rd_off`. For writes, off is `cfg_cs_wr_off`.
- R4: Address-valid is low in ticks t where `cfg_adv_on` <= t < off. For reads, off is `cfg_adv_rd_off`. For writes, off is `cfg_adv_wr_off`.
- R5: Output-enable is low only on reads, in ticks [`cfg_oe_on`, `cfg_oe_off`). Write-enable is low only on writes, in ticks [`cfg_we_on`, `cfg_we_off`). The two are never low together.
- R6: On a read, `mem_ad_in` is sampled at the clock edge that ends tick `cfg_access`. The sampled value appears on `done_rdata` while `done` is high.
- R7: `done` is high for exactly one clock, in cycle c = L*(d+1) + S. L is `cfg_rd_cycle` for reads and `cfg_wr_cycle` for writes. S is the number of stalled edges. `req_ready` is high in that cycle.
- R8: If waiting is enabled for the current direction (`cfg_wait_rd_en` or `cfg_wait_wr_en`), every tick edge at tick `cfg_access` with `mem_wait` high leaves the tick unchanged. Strobes then hold, and the sample point and completion move later. If waiting is disabled for the current direction, `mem_wait` has no effect.
- R9: With `cfg_mux`=0 (non-multiplexed), the bus is driven with write data for the whole write access and is released on reads. `mem_addr` carries the request address during the access.
- R10: With `cfg_mux`=2 (address-data), the bus carries address bits [DATA_W-1:0] while address-valid is low. After the address-valid off tick, writes drive the write data and reads release the bus. Before the address-valid on tick, the bus is released.
- R11: With `cfg_mux`=1 (address-address-data), the bus carries address bits above DATA_W, zero-extended, in ticks before `cfg_adv_on`. It carries the low address bits while address-valid is low. After the off tick it behaves as in R10.
- R12: A request is taken only while `req_ready` is high. A request held during a busy access is ignored until the done cycle, and is then taken at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| cfg_div | input | 2 | Tick divider, tick = d+1 clocks |
| cfg_mux | input | 2 | Bus mode: 0 plain, 1 addr-addr-data, 2 addr-data |
| cfg_cs_on | input | TICK_W | Chip-select on tick |
| cfg_cs_rd_off | input | TICK_W | Chip-select off tick, reads |
| cfg_cs_wr_off | input | TICK_W | Chip-select off tick, writes |
| cfg_adv_on | input | TICK_W | Address-valid on tick |
| cfg_adv_rd_off | input | TICK_W | Address-valid off tick, reads |
| cfg_adv_wr_off | input | TICK_W | Address-valid off tick, writes |
| cfg_oe_on | input | TICK_W | Output-enable on tick |
| cfg_oe_off | input | TICK_W | Output-enable off tick |
| cfg_we_on | input | TICK_W | Write-enable on tick |
| cfg_we_off | input | TICK_W | Write-enable off tick |
| cfg_access | input | TICK_W | Read sample / wait tick |
| cfg_rd_cycle | input | TICK_W | Read cycle length in ticks |
| cfg_wr_cycle | input | TICK_W | Write cycle length in ticks |
| cfg_wait_rd_en | input | 1 | Wait monitoring on reads |
| cfg_wait_wr_en | input | 1 | Wait monitoring on writes |
| mem_wait | input | 1 | Wait from memory, active high, synchronous |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_adv_n | output | 1 | Address-valid, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_addr | output | ADDR_W | Address port |
| mem_ad_out | output | DATA_W | Shared bus output value |
| mem_ad_oe | output | 1 | Shared bus output enable |
| mem_ad_in | input | DATA_W | Shared bus input value |
| done | output | 1 | One-clock end-of-access pulse |
| done_rdata | output | DATA_W | Read data, valid with done |

## Verification
The bench uses the default parameters: a 24-bit address, a 16-bit bus and 6-bit tick fields. With these, the upper address half is visible in address-address-data mode, and cycle lengths up to 63 ticks could be set. Timing values stay small, so each access lasts only a few dozen clocks. Divider values 0, 2 and 3 show the tick stretching. Stalls are applied with the divider at 0, so that the length of each stall, in clock edges, is exact. A different value is placed on the input bus in every cycle, so a sample taken one cycle early or late returns the wrong word.

// File: rtl/amem_pkg.sv
package amem_pkg;

  typedef enum logic [1:0] {
    MUX_NONE = 2'd0,
    MUX_AAD  = 2'd1,
    MUX_AD   = 2'd2,
    MUX_RSVD = 2'd3
  } mux_mode_e;

endpackage

// File: rtl/amem_rst_sync.sv
module amem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/amem_tick_gen.sv
module amem_tick_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [1:0] div,
  output logic       tick_en
);
  logic [1:0] pre_q, pre_d;

  assign tick_en = run && (pre_q == div);

  always_comb begin
    if (start)        pre_d = 2'd0;
    else if (!run)    pre_d = 2'd0;
    else if (tick_en) pre_d = 2'd0;
    else              pre_d = pre_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= 2'd0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/amem_tick_counter.sv
module amem_tick_counter #(
  parameter int TICK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              tick_en,
  input  logic              stall,
  input  logic [TICK_W-1:0] cycle_len,
  output logic [TICK_W-1:0] tick,
  output logic              finish
);
  localparam int CMP_W = TICK_W + 1;

  logic [TICK_W-1:0] tick_q, tick_d;
  logic [CMP_W-1:0]  tick_plus;
  logic              advance;

  assign tick_plus = {1'b0, tick_q} + CMP_W'(1);
  assign advance   = run && tick_en && !stall;
  assign finish    = advance && (tick_plus >= {1'b0, cycle_len});
  assign tick      = tick_q;

  always_comb begin
    tick_d = tick_q;
    if (start)                  tick_d = '0;
    else if (advance && !finish) tick_d = tick_plus[TICK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end
endmodule

// File: rtl/amem_strobe_dec.sv
module amem_strobe_dec
  import amem_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int TICK_W = 6
) (
  input  logic              busy,
  input  logic              wr,
  input  logic [TICK_W-1:0] tick,
  input  mux_mode_e         mode,
  input  logic [TICK_W-1:0] cs_on,
  input  logic [TICK_W-1:0] cs_rd_off,
  input  logic [TICK_W-1:0] cs_wr_off,
  input  logic [TICK_W-1:0] adv_on,
  input  logic [TICK_W-1:0] adv_rd_off,
  input  logic [TICK_W-1:0] adv_wr_off,
  input  logic [TICK_W-1:0] oe_on,
  input  logic [TICK_W-1:0] oe_off,
  input  logic [TICK_W-1:0] we_on,
  input  logic [TICK_W-1:0] we_off,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              cs_n,
  output logic              adv_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  function automatic logic in_win(input logic [TICK_W-1:0] t,
                                  input logic [TICK_W-1:0] on_t,
                                  input logic [TICK_W-1:0] off_t);
    return (t >= on_t) && (t < off_t);
  endfunction

  logic [TICK_W-1:0] cs_off_sel, adv_off_sel;
  logic              cs_act, adv_act, oe_act, we_act, past_adv, pre_adv;
  logic [DATA_W-1:0] addr_lo, addr_hi;

  assign cs_off_sel  = wr ? cs_wr_off  : cs_rd_off;
  assign adv_off_sel = wr ? adv_wr_off : adv_rd_off;
  assign addr_lo     = addr[DATA_W-1:0];
  assign addr_hi     = DATA_W'(addr >> DATA_W);

  always_comb begin
    cs_act   = busy && in_win(tick, cs_on, cs_off_sel);
    adv_act  = busy && in_win(tick, adv_on, adv_off_sel);
    oe_act   = busy && !wr && in_win(tick, oe_on, oe_off);
    we_act   = busy &&  wr && in_win(tick, we_on, we_off);
    past_adv = tick >= adv_off_sel;
    pre_adv  = tick < adv_on;
  end

  assign cs_n  = !cs_act;
  assign adv_n = !adv_act;
  assign oe_n  = !oe_act;
  assign we_n  = !we_act;

  always_comb begin
    bus_oe  = 1'b0;
    bus_out = '0;
    unique case (mode)
      MUX_AD: begin
        if (adv_act) begin
          bus_oe  = 1'b1;
          bus_out = addr_lo;
        end else if (busy && wr && past_adv) begin
          bus_oe  = 1'b1;
          bus_out = wdata;
        end
      end
      MUX_AAD: begin
        if (busy && pre_adv) begin
          bus_oe  = 1'b1;
          bus_out = addr_hi;
        end else if (adv_act) begin
          bus_oe  = 1'b1;
          bus_out = addr_lo;
        end else if (busy && wr && past_adv) begin
          bus_oe  = 1'b1;
          bus_out = wdata;
        end
      end
      default: begin
        if (busy && wr) begin
          bus_oe  = 1'b1;
          bus_out = wdata;
        end
      end
    endcase
  end
endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
  import amem_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int TICK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic [1:0]        cfg_div,
  input  logic [1:0]        cfg_mux,
  input  logic [TICK_W-1:0] cfg_cs_on,
  input  logic [TICK_W-1:0] cfg_cs_rd_off,
  input  logic [TICK_W-1:0] cfg_cs_wr_off,
  input  logic [TICK_W-1:0] cfg_adv_on,
  input  logic [TICK_W-1:0] cfg_adv_rd_off,
  input  logic [TICK_W-1:0] cfg_adv_wr_off,
  input  logic [TICK_W-1:0] cfg_oe_on,
  input  logic [TICK_W-1:0] cfg_oe_off,
  input  logic [TICK_W-1:0] cfg_we_on,
  input  logic [TICK_W-1:0] cfg_we_off,
  input  logic [TICK_W-1:0] cfg_access,
  input  logic [TICK_W-1:0] cfg_rd_cycle,
  input  logic [TICK_W-1:0] cfg_wr_cycle,
  input  logic              cfg_wait_rd_en,
  input  logic              cfg_wait_wr_en,
  input  logic              mem_wait,
  output logic              mem_cs_n,
  output logic              mem_adv_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_ad_out,
  output logic              mem_ad_oe,
  input  logic [DATA_W-1:0] mem_ad_in,
  output logic              done,
  output logic [DATA_W-1:0] done_rdata
);
  logic              rst_n_sync;
  logic              busy_q, busy_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic              accept, tick_en, stall, finish, capture, wait_en;
  logic [TICK_W-1:0] tick, cycle_len;

  amem_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign accept    = req_valid && !busy_q;
  assign wait_en   = wr_q ? cfg_wait_wr_en : cfg_wait_rd_en;
  assign stall     = busy_q && wait_en && mem_wait && (tick == cfg_access);
  assign cycle_len = wr_q ? cfg_wr_cycle : cfg_rd_cycle;
  assign capture   = busy_q && !wr_q && tick_en && !stall && (tick == cfg_access);

  amem_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .start   (accept),
    .run     (busy_q),
    .div     (cfg_div),
    .tick_en (tick_en)
  );

  amem_tick_counter #(.TICK_W(TICK_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .start     (accept),
    .run       (busy_q),
    .tick_en   (tick_en),
    .stall     (stall),
    .cycle_len (cycle_len),
    .tick      (tick),
    .finish    (finish)
  );

  always_comb begin
    busy_d = busy_q;
    if (accept)      busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  rdata_q <= '0;
    else if (capture) rdata_q <= mem_ad_in;
  end

  amem_strobe_dec #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TICK_W (TICK_W)
  ) u_dec (
    .busy       (busy_q),
    .wr         (wr_q),
    .tick       (tick),
    .mode       (mux_mode_e'(cfg_mux)),
    .cs_on      (cfg_cs_on),
    .cs_rd_off  (cfg_cs_rd_off),
    .cs_wr_off  (cfg_cs_wr_off),
    .adv_on     (cfg_adv_on),
    .adv_rd_off (cfg_adv_rd_off),
    .adv_wr_off (cfg_adv_wr_off),
    .oe_on      (cfg_oe_on),
    .oe_off     (cfg_oe_off),
    .we_on      (cfg_we_on),
    .we_off     (cfg_we_off),
    .addr       (addr_q),
    .wdata      (wdata_q),
    .cs_n       (mem_cs_n),
    .adv_n      (mem_adv_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .bus_out    (mem_ad_out),
    .bus_oe     (mem_ad_oe)
  );

  assign req_ready  = !busy_q;
  assign mem_addr   = addr_q;
  assign done       = done_q;
  assign done_rdata = rdata_q;
endmodule

// File: rtl/amem_strobe_seq_chk.sv
module amem_strobe_seq_chk #(
  parameter int TICK_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              cs_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              bus_oe,
  input logic              stall,
  input logic [TICK_W-1:0] tick
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && adv_n && oe_n && we_n && !bus_oe));

  assert_oe_we_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_take_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && stall) |=> ($stable(tick) && !req_ready));
endmodule

bind amem_strobe_seq amem_strobe_seq_chk #(.TICK_W(TICK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .cs_n      (mem_cs_n),
  .adv_n     (mem_adv_n),
  .oe_n      (mem_oe_n),
  .we_n      (mem_we_n),
  .bus_oe    (mem_ad_oe),
  .stall     (stall),
  .tick      (tick)
);

// File: tb/sim_amem_strobe_seq.sv
module sim_amem_strobe_seq;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready;
  logic [1:0]    cfg_div, cfg_mux;
  logic [TW-1:0] cfg_cs_on, cfg_cs_rd_off, cfg_cs_wr_off;
  logic [TW-1:0] cfg_adv_on, cfg_adv_rd_off, cfg_adv_wr_off;
  logic [TW-1:0] cfg_oe_on, cfg_oe_off, cfg_we_on, cfg_we_off;
  logic [TW-1:0] cfg_access, cfg_rd_cycle, cfg_wr_cycle;
  logic          cfg_wait_rd_en, cfg_wait_wr_en, mem_wait;
  logic          mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_ad_out, mem_ad_in;
  logic          mem_ad_oe;
  logic          done;
  logic [DW-1:0] done_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  amem_strobe_seq #(.ADDR_W(AW), .DATA_W(DW), .TICK_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .cfg_div(cfg_div), .cfg_mux(cfg_mux),
    .cfg_cs_on(cfg_cs_on), .cfg_cs_rd_off(cfg_cs_rd_off), .cfg_cs_wr_off(cfg_cs_wr_off),
    .cfg_adv_on(cfg_adv_on), .cfg_adv_rd_off(cfg_adv_rd_off), .cfg_adv_wr_off(cfg_adv_wr_off),
    .cfg_oe_on(cfg_oe_on), .cfg_oe_off(cfg_oe_off),
    .cfg_we_on(cfg_we_on), .cfg_we_off(cfg_we_off),
    .cfg_access(cfg_access), .cfg_rd_cycle(cfg_rd_cycle), .cfg_wr_cycle(cfg_wr_cycle),
    .cfg_wait_rd_en(cfg_wait_rd_en), .cfg_wait_wr_en(cfg_wait_wr_en),
    .mem_wait(mem_wait),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe),
    .mem_ad_in(mem_ad_in), .done(done), .done_rdata(done_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic base_timing();
    cfg_div = 2'd0; cfg_mux = 2'd0;
    cfg_cs_on = 6'd1;  cfg_cs_rd_off = 6'd9;  cfg_cs_wr_off = 6'd7;
    cfg_adv_on = 6'd1; cfg_adv_rd_off = 6'd3; cfg_adv_wr_off = 6'd4;
    cfg_oe_on = 6'd3;  cfg_oe_off = 6'd8;
    cfg_we_on = 6'd2;  cfg_we_off = 6'd6;
    cfg_access = 6'd6; cfg_rd_cycle = 6'd10; cfg_wr_cycle = 6'd8;
    cfg_wait_rd_en = 1'b0; cfg_wait_wr_en = 1'b0;
  endtask

  // One access, checked clock by clock against the requirement model.
  task automatic run_access(input bit wr, input logic [AW-1:0] addr,
                            input logic [DW-1:0] wd, input int nstall,
                            input bit wait_always, input bit skip_issue,
                            input bit queue_next, input string tag);
    int k, len, acc, done_exp, cap_clk, done_at, t;
    int e_cs, e_adv, e_rw, e_bus;
    bit busy_e, cs_e, adv_e, oe_e, we_e, boe_e;
    logic [DW-1:0] bval_e, rd_exp;
    string bus_tag;
    k = int'(cfg_div) + 1;
    len = wr ? int'(cfg_wr_cycle) : int'(cfg_rd_cycle);
    acc = int'(cfg_access);
    done_exp = len * k + nstall;
    cap_clk = acc * k + (k - 1) + nstall;
    done_at = -1; e_cs = 0; e_adv = 0; e_rw = 0; e_bus = 0; rd_exp = '0;
    bus_tag = (cfg_mux == 2'd2) ? "R10" : (cfg_mux == 2'd1) ? "R11" : "R9";
    if (!skip_issue) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 400; c++) begin
      if (c > 0) @(negedge clk);
      if (nstall > 0) t = (c <= acc) ? c : ((c <= acc + nstall) ? acc : c - nstall);
      else            t = c / k;
      busy_e = (c < done_exp);
      cs_e  = busy_e && t >= int'(cfg_cs_on) &&
              t < (wr ? int'(cfg_cs_wr_off) : int'(cfg_cs_rd_off));
      adv_e = busy_e && t >= int'(cfg_adv_on) &&
              t < (wr ? int'(cfg_adv_wr_off) : int'(cfg_adv_rd_off));
      oe_e  = busy_e && !wr && t >= int'(cfg_oe_on) && t < int'(cfg_oe_off);
      we_e  = busy_e &&  wr && t >= int'(cfg_we_on) && t < int'(cfg_we_off);
      boe_e = 1'b0; bval_e = '0;
      if (cfg_mux == 2'd2 || cfg_mux == 2'd1) begin
        if (cfg_mux == 2'd1 && busy_e && t < int'(cfg_adv_on)) begin
          boe_e = 1'b1; bval_e = DW'(addr >> DW);
        end else if (adv_e) begin
          boe_e = 1'b1; bval_e = addr[DW-1:0];
        end else if (busy_e && wr &&
                     t >= (wr ? int'(cfg_adv_wr_off) : int'(cfg_adv_rd_off))) begin
          boe_e = 1'b1; bval_e = wd;
        end
      end else if (busy_e && wr) begin
        boe_e = 1'b1; bval_e = wd;
      end
      if (mem_cs_n !== !cs_e) e_cs++;
      if (mem_adv_n !== !adv_e) e_adv++;
      if (mem_oe_n !== !oe_e || mem_we_n !== !we_e) e_rw++;
      if (mem_ad_oe !== boe_e || (boe_e && mem_ad_out !== bval_e)) e_bus++;
      if (busy_e && mem_addr !== addr) e_bus++;
      if (c == cap_clk) rd_exp = DW'(32'hA000 + c);
      mem_ad_in = DW'(32'hA000 + c);
      mem_wait  = wait_always ? 1'b1 : (nstall > 0 && c >= acc && c < acc + nstall);
      if (queue_next && c == 3) begin
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = 24'h5A_1234; req_wdata = 16'hBEEF;
      end
      if (done === 1'b1) begin
        done_at = c;
        if (!wr) check(done_rdata === rd_exp, "R6", "read data", done_rdata, rd_exp);
        check(req_ready === 1'b1, "R7", "ready in done cycle", req_ready, 1);
        break;
      end
    end
    mem_wait = 1'b0;
    check(e_cs == 0, "R3", "chip-select mismatching cycles", e_cs, 0);
    check(e_adv == 0, "R4", "address-valid mismatching cycles", e_adv, 0);
    check(e_rw == 0, "R5", "oe/we mismatching cycles", e_rw, 0);
    check(e_bus == 0, bus_tag, "bus/address mismatching cycles", e_bus, 0);
    check(done_at == done_exp, tag, "done cycle", done_at, done_exp);
  endtask

  task automatic t_reset();
    check(req_ready === 1'b1 && done === 1'b0, "R1", "ready/done after reset",
          {req_ready, done}, 2'b10);
    check(mem_cs_n === 1'b1 && mem_adv_n === 1'b1 && mem_oe_n === 1'b1 &&
          mem_we_n === 1'b1 && mem_ad_oe === 1'b0, "R1", "idle strobes",
          {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe}, 5'b11110);
  endtask

  task automatic t_plain();
    base_timing();
    run_access(1'b0, 24'h12_3456, 16'h0, 0, 1'b0, 1'b0, 1'b0, "R7");
    run_access(1'b1, 24'h00_0ABC, 16'hC3C3, 0, 1'b0, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_divider();
    base_timing();
    cfg_div = 2'd2;
    run_access(1'b0, 24'h01_0203, 16'h0, 0, 1'b0, 1'b0, 1'b0, "R2");
    cfg_div = 2'd3;
    run_access(1'b1, 24'h04_0506, 16'h7171, 0, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_wait();
    base_timing();
    cfg_wait_rd_en = 1'b1;
    run_access(1'b0, 24'h22_2222, 16'h0, 4, 1'b0, 1'b0, 1'b0, "R8");
    cfg_wait_rd_en = 1'b0; cfg_wait_wr_en = 1'b1;
    run_access(1'b0, 24'h33_3333, 16'h0, 0, 1'b1, 1'b0, 1'b0, "R8");
    run_access(1'b1, 24'h44_4444, 16'h9999, 3, 1'b0, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_mux();
    base_timing();
    cfg_mux = 2'd2;
    run_access(1'b0, 24'hAB_CDEF, 16'h0, 0, 1'b0, 1'b0, 1'b0, "R10");
    run_access(1'b1, 24'h76_5432, 16'h1357, 0, 1'b0, 1'b0, 1'b0, "R10");
    cfg_mux = 2'd1;
    cfg_adv_on = 6'd2; cfg_adv_rd_off = 6'd4; cfg_adv_wr_off = 6'd5;
    run_access(1'b0, 24'hC1_D2E3, 16'h0, 0, 1'b0, 1'b0, 1'b0, "R11");
    run_access(1'b1, 24'h9F_8E7D, 16'h2468, 0, 1'b0, 1'b0, 1'b0, "R11");
  endtask

  task automatic t_busy_req();
    base_timing();
    run_access(1'b0, 24'h11_1111, 16'h0, 0, 1'b0, 1'b0, 1'b1, "R12");
    run_access(1'b1, 24'h5A_1234, 16'hBEEF, 0, 1'b0, 1'b1, 1'b0, "R12");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    mem_wait = 1'b0; mem_ad_in = '0;
    base_timing();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_divider();
    t_wait();
    t_mux();
    t_busy_req();
    repeat (3) @(negedge clk);
    t_reset();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule